// File: doc/BRIEF.md
# Catch-up Periodic Tick Scheduler

This block turns a free-running cycle counter into a steady periodic tick. A 32-bit compare value is checked for equality against the low 32 bits of the counter. A match sets a sticky pending flag, and that flag drives a maskable interrupt. When the interrupt is acknowledged, the block works out how many whole periods have gone by since the last accounted tick. It reports that number on a small output stream. It then re-arms the compare value to a future point on the same period grid, so the tick phase never drifts however late the service comes.

All distances are unsigned modular 32-bit differences, so the scheduling works across counter wrap. Catch-up runs as a sequential engine that adds at most one period per clock. A programmable guard distance keeps the block from arming a boundary that is too close to be delivered. Boundaries skipped while re-arming are not reported then. They appear in the count of the following service.

The elapsed-tick count leaves on a valid/ready interface. While `tick_valid` is high and `tick_ready` is low, the count holds steady and the engine waits: the counter is not re-sampled and no new compare value is armed until the transfer completes. Back-pressure therefore only delays re-arming. It never loses or changes a count.

Top module: `tick_sched`

## Requirements
- R1: After reset is released, `count` starts from the parameter `CNT_INIT` and grows by exactly one on every clock.
- R2: During and straight after reset, `irq`, `tick_valid` and `busy` are low; the step is `PERIOD_RST` and the guard is `GUARD_RST`.
- R3: When `enable` is high in the idle state and the step is nonzero, the engine arms compare = low count + step and stores the same value as the accounting base. The pending flag sets on the clock edge where the low 32 bits of the count equal the compare value, so `irq` is first high when `count` reads compare + 1.
- R4: Pending is sticky. `irq_ack` clears it. An `irq_ack` with nothing pending starts nothing. `irq_mask` hides pending at `irq` but leaves the flag itself unchanged.
- R5: `irq_ack` while armed and pending samples the low count N. The engine then repeatedly adds the step to the base, counting one tick per addition, until (base − N) mod 2^32 ≤ step. It presents that count (always ≥ 1) with `tick_valid` and `busy` high, and holds it stable until `tick_ready`.
- R6: On the transfer, the low count M is sampled and the target starts at the new base. The step is added while (target − M) mod 2^32 > step.
- R7: If (target − M) mod 2^32 ≤ guard afterwards, one more step is added before the compare value is written.
- R8: The next service counts from the base, not from the armed target, so boundaries skipped in R6/R7 are counted then.
- R9: All distances wrap safely across 2^32 of the low count; `count` carries into its upper bits.
- R10: With a step of zero the engine never arms, and an `irq_ack` only clears pending.
- R11: A write on `cfg_we` while `busy` is high is ignored; at any other time the step and guard load the next cycle.
- R12: `enable` low returns the engine to idle at once. No further matches occur, but an existing pending flag is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the scheduler; low forces idle |
| irq_mask | input | 1 | Hides pending at `irq` |
| irq_ack | input | 1 | Clears pending; starts service when pending and armed |
| cfg_we | input | 1 | Loads step and guard when not busy |
| cfg_period | input | CMP_W | Step in cycles |
| cfg_guard | input | CMP_W | Minimum distance for an armed boundary |
| tick_ready | input | 1 | Consumer accepts the count |
| irq | output | 1 | Masked pending interrupt |
| tick_valid | output | 1 | Elapsed count is presented |
| tick_count | output | TICK_W | Elapsed whole periods |
| busy | output | 1 | Service in progress, compare not yet committed |
| count | output | CNT_W | Free-running counter read port |

## Verification
A wrong accounting base shows up as a wrong `tick_count` at the very next service, or one service late when the fault only touches skipped boundaries. A wrong target or guard decision moves the cycle at which `irq` rises. It can push it later by whole steps, or in the worst case by a full 2^32 wrap. So every service is checked by the `count` value observed when `irq` next goes high. A stuck or misrouted pending flag shows at `irq` within one cycle of a match, an acknowledge or a mask change.

// File: rtl/tick_pkg.sv
package tick_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_ACCT,
    ST_REPORT,
    ST_SKIP,
    ST_GUARD
  } eng_st_t;
endpackage

// File: rtl/tick_free_cnt.sv
module tick_free_cnt #(
  parameter int          CNT_W    = 64,
  parameter logic [63:0] CNT_INIT = 64'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] INIT_V = CNT_INIT[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_o <= INIT_V;
    else        cnt_o <= cnt_o + 1'b1;
  end

  // R1: one step per clock
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt_o == $past(cnt_o) + 1'b1);
endmodule

// File: rtl/tick_cfg.sv
module tick_cfg #(
  parameter int             W       = 32,
  parameter logic [W-1:0]   PER_RST = '0,
  parameter logic [W-1:0]   GRD_RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busy_i,
  input  logic         we_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] guard_i,
  output logic [W-1:0] period_o,
  output logic [W-1:0] guard_o
);
  logic load;
  assign load = we_i && !busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_o <= PER_RST;
      guard_o  <= GRD_RST;
    end else if (load) begin
      period_o <= period_i;
      guard_o  <= guard_i;
    end
  end

  // R11: settings frozen while a service runs
  a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(period_o) && $stable(guard_o));
endmodule

// File: rtl/tick_pend.sv
module tick_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic match_i,
  input  logic ack_i,
  input  logic mask_i,
  output logic pend_o,
  output logic irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_o <= 1'b0;
    else if (match_i) pend_o <= 1'b1;
    else if (ack_i)   pend_o <= 1'b0;
  end

  assign irq_o = pend_o && !mask_i;

  // R4: sticky until acknowledged
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o && !ack_i |=> pend_o);
  // R3: a match always leaves pending set
  a_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
    match_i |=> pend_o);
endmodule

// File: rtl/tick_engine.sv
module tick_engine
  import tick_pkg::*;
#(
  parameter int W      = 32,
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [W-1:0]      cnt_lo_i,
  input  logic [W-1:0]      period_i,
  input  logic [W-1:0]      guard_i,
  input  logic              pend_i,
  input  logic              ack_i,
  input  logic              rdy_i,
  output logic              match_o,
  output logic              valid_o,
  output logic [TICK_W-1:0] tick_o,
  output logic              busy_o
);
  eng_st_t            st;
  logic [W-1:0]       cmp_q;
  logic [W-1:0]       acct_q;
  logic [W-1:0]       tgt_q;
  logic [W-1:0]       now_q;
  logic [TICK_W-1:0]  n_q;

  logic [W-1:0] acct_nxt;
  logic [W-1:0] acct_gap;
  logic [W-1:0] tgt_gap;
  logic         step_ok;

  assign acct_nxt = acct_q + period_i;
  assign acct_gap = acct_nxt - now_q;
  assign tgt_gap  = tgt_q - now_q;
  assign step_ok  = period_i != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cmp_q  <= '0;
      acct_q <= '0;
      tgt_q  <= '0;
      now_q  <= '0;
      n_q    <= '0;
    end else if (!en_i) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE: if (step_ok) begin
          cmp_q  <= cnt_lo_i + period_i;
          acct_q <= cnt_lo_i + period_i;
          st     <= ST_ARMED;
        end
        ST_ARMED: if (ack_i && pend_i && step_ok) begin
          now_q <= cnt_lo_i;
          n_q   <= '0;
          st    <= ST_ACCT;
        end
        ST_ACCT: begin
          acct_q <= acct_nxt;
          if (n_q != '1) n_q <= n_q + 1'b1;
          if (acct_gap <= period_i) st <= ST_REPORT;
        end
        ST_REPORT: if (rdy_i) begin
          now_q <= cnt_lo_i;
          tgt_q <= acct_q;
          st    <= ST_SKIP;
        end
        ST_SKIP: begin
          if (tgt_gap > period_i) tgt_q <= tgt_q + period_i;
          else                    st    <= ST_GUARD;
        end
        ST_GUARD: begin
          cmp_q <= (tgt_gap <= guard_i) ? tgt_q + period_i : tgt_q;
          st    <= ST_ARMED;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign match_o = (st == ST_ARMED) && (cnt_lo_i == cmp_q);
  assign valid_o = (st == ST_REPORT);
  assign tick_o  = n_q;
  assign busy_o  = (st == ST_ACCT) || (st == ST_REPORT) ||
                   (st == ST_SKIP) || (st == ST_GUARD);

  // R5: count held while back-pressured
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !rdy_i && en_i |=> valid_o && $stable(tick_o));
  // R5: a reported service covers at least one period
  a_r5_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> tick_o != '0);
  // R10: a zero step never enters accounting
  a_r10_no_zero_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ARMED) && !step_ok |=> st != ST_ACCT);
  // R12: disable drops any service
  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !busy_o && !match_o);
endmodule

// File: rtl/tick_sched.sv
module tick_sched #(
  parameter int          CNT_W      = 64,
  parameter int          CMP_W      = 32,
  parameter int          TICK_W     = 16,
  parameter logic [63:0] CNT_INIT   = 64'd0,
  parameter logic [31:0] PERIOD_RST = 32'd100000,
  parameter logic [31:0] GUARD_RST  = 32'd8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              irq_mask,
  input  logic              irq_ack,
  input  logic              cfg_we,
  input  logic [CMP_W-1:0]  cfg_period,
  input  logic [CMP_W-1:0]  cfg_guard,
  input  logic              tick_ready,
  output logic              irq,
  output logic              tick_valid,
  output logic [TICK_W-1:0] tick_count,
  output logic              busy,
  output logic [CNT_W-1:0]  count
);
  logic [CMP_W-1:0] period_q;
  logic [CMP_W-1:0] guard_q;
  logic [CMP_W-1:0] cnt_lo;
  logic             match;
  logic             pend;

  assign cnt_lo = count[CMP_W-1:0];

  tick_free_cnt #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_o(count)
  );

  tick_cfg #(
    .W(CMP_W),
    .PER_RST(PERIOD_RST[CMP_W-1:0]),
    .GRD_RST(GUARD_RST[CMP_W-1:0])
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .we_i(cfg_we),
    .period_i(cfg_period), .guard_i(cfg_guard),
    .period_o(period_q), .guard_o(guard_q)
  );

  tick_pend u_pend (
    .clk(clk), .rst_n(rst_n), .match_i(match), .ack_i(irq_ack),
    .mask_i(irq_mask), .pend_o(pend), .irq_o(irq)
  );

  tick_engine #(.W(CMP_W), .TICK_W(TICK_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .en_i(enable), .cnt_lo_i(cnt_lo),
    .period_i(period_q), .guard_i(guard_q), .pend_i(pend),
    .ack_i(irq_ack), .rdy_i(tick_ready), .match_o(match),
    .valid_o(tick_valid), .tick_o(tick_count), .busy_o(busy)
  );

  // R2: quiet outputs in the first cycle after reset
  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !tick_valid && !busy);
endmodule

// File: tb/sim_tick_sched.sv
`timescale 1ns/1ps
module sim_tick_sched;
  localparam logic [63:0] INIT = 64'h0000_0000_FFFF_FCE0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, irq_mask = 1'b0, irq_ack = 1'b0;
  logic        cfg_we = 1'b0, tick_ready = 1'b0;
  logic [31:0] cfg_period = '0, cfg_guard = '0;
  logic        irq, tick_valid, busy;
  logic [15:0] tick_count;
  logic [63:0] count;
  logic [31:0] cnt_lo;
  assign cnt_lo = count[31:0];

  always #4 clk = ~clk;

  tick_sched #(.CNT_INIT(INIT)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .irq_mask(irq_mask),
    .irq_ack(irq_ack), .cfg_we(cfg_we), .cfg_period(cfg_period),
    .cfg_guard(cfg_guard), .tick_ready(tick_ready), .irq(irq),
    .tick_valid(tick_valid), .tick_count(tick_count), .busy(busy),
    .count(count)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] P = 32'd100, G = 32'd20, E;
  bit prev_skip = 0;

  // {ack offset from base, ready offset from new base, config poke}
  localparam int VEC [7][3] = '{
    '{1, -70, 0}, '{250, -15, 0}, '{50, 250, 0}, '{1, -20, 0},
    '{1, -21, 0}, '{1, 0, 0}, '{180, 100, 1}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic cfg(input logic [31:0] p, input logic [31:0] g);
    cfg_we = 1; cfg_period = p; cfg_guard = g;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic service(input int ackoff, input int rdyoff, input bit poke);
    logic [31:0] a, b, A, t;
    int n;
    bit skip, grd;
    string tg;
    while (!(irq && $signed(cnt_lo - E) >= ackoff)) @(negedge clk);
    a = cnt_lo;
    irq_ack = 1;
    @(negedge clk);
    irq_ack = 0;
    n = 0; A = E;
    do begin A += P; n++; end while ((A - a) > P);
    while (!tick_valid) @(negedge clk);
    check(prev_skip ? "R8" : "R5", tick_count, n);
    check("R5 busy", busy, 1);
    if (poke) begin
      cfg_we = 1; cfg_period = 32'd40; cfg_guard = 32'd5;   // R11: must be ignored
    end
    @(negedge clk);
    cfg_we = 0;
    check("R5 hold", {tick_valid, tick_count}, {1'b1, n[15:0]});
    while ($signed(cnt_lo - A) < rdyoff) @(negedge clk);
    b = cnt_lo;
    tick_ready = 1;
    @(negedge clk);
    tick_ready = 0;
    check("R5 drop", tick_valid, 0);
    t = A; skip = 0;
    while ((t - b) > P) begin t += P; skip = 1; end
    grd = (t - b) <= G;
    if (grd) t += P;
    tg = poke ? "R11" : (grd ? "R7" : "R6");
    while (!irq) @(negedge clk);
    check(tg, cnt_lo, t + 1);
    prev_skip = skip || grd;
    E = A;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] c0;
    repeat (3) @(negedge clk);
    check("R2 irq", irq, 0);
    check("R2 busy", busy, 0);
    check("R1 hold", count, INIT);
    rst_n = 1;
    @(negedge clk);
    check("R1", count, INIT + 1);
    check("R2 valid", tick_valid, 0);
    @(negedge clk);
    check("R1", count, INIT + 2);

    cfg(P, G);
    enable = 1; c0 = cnt_lo;
    @(negedge clk);
    irq_ack = 1;                       // R4: nothing pending, no service
    @(negedge clk);
    irq_ack = 0;
    @(negedge clk);
    check("R4 idle ack", busy, 0);
    while (!irq) @(negedge clk);
    check("R3", cnt_lo, c0 + P + 1);
    E = c0 + P;

    for (int i = 0; i < 7; i++) service(VEC[i][0], VEC[i][1], VEC[i][2] != 0);

    irq_mask = 1;
    @(negedge clk);
    check("R4 mask", irq, 0);
    irq_mask = 0;
    @(negedge clk);
    check("R4 kept", irq, 1);

    enable = 0;
    repeat (2) @(negedge clk);
    check("R12 pending kept", irq, 1);
    irq_ack = 1;
    @(negedge clk);
    irq_ack = 0;
    repeat (300) @(negedge clk);
    check("R12 no match", {irq, busy, tick_valid}, 3'b000);

    cfg(32'd0, G);
    enable = 1;
    repeat (300) @(negedge clk);
    check("R10", {irq, busy}, 2'b00);
    c0 = cnt_lo;
    cfg(P, G);
    while (!irq) @(negedge clk);
    check("R3 restart", cnt_lo, c0 + P + 2);

    check("R9 carry", count[63:32], 32'd1);
    summary();
  end
endmodule